// File: doc/BRIEF.md
# Adaptive Routing Mode Controller

This controller decides, for a whole on-chip mesh, which of two routing modes the route computation units use. In the task-based mode (TB, output value 0), requests and replies take different dimension orders but share both virtual channels, one acting as an escape lane. In the partitioned mode (TBP, output value 1), each virtual channel carries one dimension order. The controller watches CPU throughput through per-cycle retired-instruction counts from every core. It runs each mode for a short window, compares the two totals, and keeps the better mode for a long window.

After reset the controller waits through a start-up period in TB mode and does not measure anything. It then enters a sampling period made of two equal halves, TB first and TBP second. During each half it adds the summed per-core counts into a saturating accumulator. At the end of the second half it keeps TB if the TB total is at least 1.5 times the TBP total, and chooses TBP otherwise. The test is done as 2·TB ≥ 3·TBP, so no divider is needed. A main period then holds that choice, after which a fresh sampling period starts with cleared totals.

Top module: `route_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 0 (TB) without waiting for a clock. After release, the controller begins a new start-up period whatever it was doing before.
- R2: The start-up period lasts `START_CYC` clock edges after reset release. During it `mode_o` is 0, and the retired counts have no effect on any later decision.
- R3: The first sampling half lasts `HALF_CYC` edges with `mode_o` = 0. On each of these edges the sum of all per-core counts (core i in bits [i*CNT_W +: CNT_W]) is added into the TB total.
- R4: The second sampling half lasts `HALF_CYC` edges with `mode_o` = 1. Its per-cycle sums are added into a separate TBP total.
- R5: On the edge that ends the second half, `mode_o` becomes 0 if 2·TB ≥ 3·TBP (equality selects TB), and 1 otherwise.
- R6: A TBP total of zero selects TB.
- R7: Each total saturates at 2^ACC_W−1 instead of wrapping, and the saturated value is the one used in the comparison.
- R8: The main period holds the chosen mode for `MAIN_CYC` edges, then `mode_o` returns to 0 and a new first sampling half begins. Counts during the main period are ignored, and both totals start from zero in every sampling period.
- R9: `mode_o` changes only on the edge that ends a period or a sampling half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| retire_cnt_i | input | NUM_CORES*CNT_W | Per-core retired-instruction count for the current cycle |
| mode_o | output | 1 | Routing mode: 0 = TB, 1 = TBP |

## Verification
The times below count clock edges after reset release, with S, H and M standing for the start-up, sampling-half and main lengths.

- `mode_o` is a register, so each change shows up on the edge that closes a period: edge S (stays TB), S+H (to TBP), S+2H (the decision) and S+2H+M (back to TB). After that the pattern repeats with period 2H+M.
- The inputs present at edge S+2H still count toward the TBP total that this decision uses.
- The driver sets the inputs at the falling edge and queues, for the rising edge that follows, the mode expected from these timing rules. The monitor checks each queued value 2 ns after that rising edge, so every cycle is checked at the point where the change is due.
- The asynchronous reset is checked 1 ns after `rst_n` falls.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [1:0] {
    PH_START  = 2'd0,
    PH_SAMP_A = 2'd1,
    PH_SAMP_B = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef enum logic {
    MODE_TB  = 1'b0,
    MODE_TBP = 1'b1
  } route_mode_e;

endpackage

// File: rtl/rmc_core_sum.sv
module rmc_core_sum #(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 4,
  parameter int SUM_W     = 7
) (
  input  logic [NUM_CORES*CNT_W-1:0] cnt_i,
  output logic [SUM_W-1:0]           sum_o
);

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      sum_o = sum_o + SUM_W'(cnt_i[i*CNT_W +: CNT_W]);
    end
  end

endmodule

// File: rtl/rmc_sat_accum.sv
module rmc_sat_accum #(
  parameter int IN_W  = 7,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [IN_W-1:0]  val_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] acc_next_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   wide;
  logic             ld_en;

  assign ld_en = clr_i | add_i;

  always_comb begin
    wide = {1'b0, acc_q} + {{(ACC_W+1-IN_W){1'b0}}, val_i};
    if (clr_i) begin
      acc_d = '0;
    end else if (wide[ACC_W]) begin
      acc_d = '1;
    end else begin
      acc_d = wide[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (ld_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o      = acc_q;
  assign acc_next_o = ld_en ? acc_d : acc_q;

  // R7: adding never lowers the total
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !clr_i) |=> (acc_q >= $past(acc_q)))
    else $error("accumulator wrapped");

  // R7: a full total stays full while adding
  p_sat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !clr_i && (acc_q == {ACC_W{1'b1}})) |=> (acc_q == {ACC_W{1'b1}}))
    else $error("saturated total changed");

  // R8: a clear empties the total
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0))
    else $error("total not cleared");

endmodule

// File: rtl/rmc_ratio_cmp.sv
module rmc_ratio_cmp #(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] tb_sum_i,
  input  logic [ACC_W-1:0] tbp_sum_i,
  output logic             pick_tbp_o
);

  localparam int CW = ACC_W + 2;

  logic [CW-1:0] twice_tb;
  logic [CW-1:0] thrice_tbp;

  always_comb begin
    twice_tb   = {1'b0, tb_sum_i, 1'b0};
    thrice_tbp = {1'b0, tbp_sum_i, 1'b0} + {2'b00, tbp_sum_i};
    pick_tbp_o = (twice_tb < thrice_tbp);
  end

endmodule

// File: rtl/rmc_phase_seq.sv
module rmc_phase_seq
  import rmc_pkg::*;
#(
  parameter int START_CYC = 1000,
  parameter int HALF_CYC  = 200,
  parameter int MAIN_CYC  = 5000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pick_tbp_i,
  output phase_e phase_o,
  output logic   last_o,
  output logic   mode_o
);

  localparam int MAX_A   = (START_CYC > HALF_CYC) ? START_CYC : HALF_CYC;
  localparam int MAX_LEN = (MAX_A > MAIN_CYC) ? MAX_A : MAIN_CYC;
  localparam int TMR_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  phase_e      phase_q, phase_d;
  logic [TMR_W-1:0] tmr_q, tmr_d, end_val;
  route_mode_e mode_q, mode_d;
  logic        last;

  always_comb begin
    unique case (phase_q)
      PH_START:  end_val = TMR_W'(START_CYC - 1);
      PH_SAMP_A: end_val = TMR_W'(HALF_CYC - 1);
      PH_SAMP_B: end_val = TMR_W'(HALF_CYC - 1);
      default:   end_val = TMR_W'(MAIN_CYC - 1);
    endcase
    last = (tmr_q == end_val);
  end

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    tmr_d   = tmr_q + TMR_W'(1);
    if (last) begin
      tmr_d = '0;
      unique case (phase_q)
        PH_START: begin
          phase_d = PH_SAMP_A;
          mode_d  = MODE_TB;
        end
        PH_SAMP_A: begin
          phase_d = PH_SAMP_B;
          mode_d  = MODE_TBP;
        end
        PH_SAMP_B: begin
          phase_d = PH_HOLD;
          mode_d  = pick_tbp_i ? MODE_TBP : MODE_TB;
        end
        default: begin
          phase_d = PH_SAMP_A;
          mode_d  = MODE_TB;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_START;
      tmr_q   <= '0;
      mode_q  <= MODE_TB;
    end else begin
      phase_q <= phase_d;
      tmr_q   <= tmr_d;
      mode_q  <= mode_d;
    end
  end

  assign phase_o = phase_q;
  assign last_o  = last;
  assign mode_o  = mode_q;

  p_startup_tb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_START) |-> (mode_q == MODE_TB))
    else $error("start-up not in TB");

  p_half_a_tb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SAMP_A) |-> (mode_q == MODE_TB))
    else $error("first half not in TB");

  p_half_b_tbp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SAMP_B) |-> (mode_q == MODE_TBP))
    else $error("second half not in TBP");

  p_mode_at_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(last))
    else $error("mode moved inside a period");

  p_tmr_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q <= end_val))
    else $error("period timer overran");

endmodule

// File: rtl/route_mode_ctrl.sv
module route_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 4,
  parameter int ACC_W     = 32,
  parameter int START_CYC = 1000,
  parameter int HALF_CYC  = 200,
  parameter int MAIN_CYC  = 5000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CORES*CNT_W-1:0] retire_cnt_i,
  output logic                       mode_o
);

  localparam int SUM_W = CNT_W + $clog2(NUM_CORES + 1);

  logic [SUM_W-1:0] cyc_sum;
  logic [ACC_W-1:0] tb_tot, tb_tot_nx;
  logic [ACC_W-1:0] tbp_tot, tbp_tot_nx;
  logic             clr_tot, add_tb, add_tbp;
  logic             pick_tbp, last;
  phase_e           phase;

  rmc_core_sum #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_sum (
    .cnt_i (retire_cnt_i),
    .sum_o (cyc_sum)
  );

  assign clr_tot = (phase == PH_START) || (phase == PH_HOLD);
  assign add_tb  = (phase == PH_SAMP_A);
  assign add_tbp = (phase == PH_SAMP_B);

  rmc_sat_accum #(.IN_W(SUM_W), .ACC_W(ACC_W)) u_acc_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_tot),
    .add_i      (add_tb),
    .val_i      (cyc_sum),
    .acc_o      (tb_tot),
    .acc_next_o (tb_tot_nx)
  );

  rmc_sat_accum #(.IN_W(SUM_W), .ACC_W(ACC_W)) u_acc_tbp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_tot),
    .add_i      (add_tbp),
    .val_i      (cyc_sum),
    .acc_o      (tbp_tot),
    .acc_next_o (tbp_tot_nx)
  );

  rmc_ratio_cmp #(.ACC_W(ACC_W)) u_cmp (
    .tb_sum_i   (tb_tot),
    .tbp_sum_i  (tbp_tot_nx),
    .pick_tbp_o (pick_tbp)
  );

  rmc_phase_seq #(
    .START_CYC (START_CYC),
    .HALF_CYC  (HALF_CYC),
    .MAIN_CYC  (MAIN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_tbp_i (pick_tbp),
    .phase_o    (phase),
    .last_o     (last),
    .mode_o     (mode_o)
  );

  // R6: an empty TBP total keeps TB
  p_zero_tbp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_SAMP_B) && last && (tbp_tot_nx == '0)) |=> (mode_o == MODE_TB))
    else $error("zero TBP total did not select TB");

  // R8: TB total untouched during the second half
  p_tb_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SAMP_B) |=> $stable(tb_tot))
    else $error("TB total moved in TBP half");

  // R1: reset holds TB
  p_reset_tb_r1: assert property (@(posedge clk) !rst_n |-> (mode_o == MODE_TB))
    else $error("mode not TB in reset");

endmodule

// File: tb/route_mode_ctrl_tb_top.sv
module route_mode_ctrl_tb_top;

  localparam int NC = 4;
  localparam int CW = 3;
  localparam int AW = 7;
  localparam int S  = 8;
  localparam int H  = 6;
  localparam int M  = 12;
  localparam int SAT = (1 << AW) - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NC*CW-1:0] retire;
  logic            mode_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  route_mode_ctrl #(
    .NUM_CORES(NC), .CNT_W(CW), .ACC_W(AW),
    .START_CYC(S), .HALF_CYC(H), .MAIN_CYC(M)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .retire_cnt_i (retire),
    .mode_o       (mode_o)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mode_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: one queued expectation per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mode_o, e, t);
      end
    end
  end

  function automatic int cyc_total(input logic [NC*CW-1:0] v);
    int t = 0;
    for (int i = 0; i < NC; i++) t += int'(v[i*CW +: CW]);
    return t;
  endfunction

  function automatic int sat_tot(input int x);
    return (x > SAT) ? SAT : x;
  endfunction

  task automatic drive_cycle(input logic [NC*CW-1:0] v, input logic exp, input string tag);
    retire = v;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // R2: start-up always TB, inputs are noise
  task automatic run_startup();
    for (int k = 1; k <= S; k++) drive_cycle(12'o7777, 1'b0, "R2");
  endtask

  task automatic run_round(input logic [NC*CW-1:0] va, input logic [NC*CW-1:0] vb,
                           input string dtag, input int main_n);
    int   sa, sb;
    logic dec;
    sa  = sat_tot(H * cyc_total(va));
    sb  = sat_tot(H * cyc_total(vb));
    dec = (sb != 0) && (2 * sa < 3 * sb);
    for (int k = 1; k <= H; k++) drive_cycle(va, (k == H) ? 1'b1 : 1'b0, "R3");
    for (int k = 1; k <= H; k++) drive_cycle(vb, (k == H) ? dec : 1'b1, (k == H) ? dtag : "R4");
    for (int k = 1; k <= main_n; k++) drive_cycle(12'o7777, (k == M) ? 1'b0 : dec, "R8");
  endtask

  initial begin
    rst_n  = 1'b0;
    retire = '0;
    repeat (3) @(negedge clk);
    check(mode_o, 1'b0, "R1");
    rst_n = 1'b1;
    run_startup();
    run_round(12'o3333, 12'o1111, "R5", M);  // 72 vs 24 -> TB
    run_round(12'o0003, 12'o0002, "R5", M);  // 18 vs 12 exact 1.5 -> TB
    run_round(12'o0113, 12'o0022, "R5", M);  // 30 vs 24 -> TBP
    run_round(12'o0000, 12'o0000, "R6", M);  // 0 vs 0 -> TB
    run_round(12'o0113, 12'o0022, "R5", M);  // back to TBP
    run_round(12'o0100, 12'o0000, "R6", M);  // 6 vs 0 -> TB
    run_round(12'o7777, 12'o4444, "R7", M);  // 127 vs 96 -> TBP (wrap-free)
    run_round(12'o0113, 12'o0022, "R5", 3);  // TBP, then reset mid-main
    rst_n = 1'b0;
    #1;
    check(mode_o, 1'b0, "R1");
    @(negedge clk);
    check(mode_o, 1'b0, "R1");
    rst_n = 1'b1;
    run_startup();
    run_round(12'o3333, 12'o1111, "R5", M);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule